// File: doc/BRIEF.md
# Two-Stage UART Tick Generator

This block produces the UART bit timing from a single module clock. A first counter divides the clock by a programmable 13-bit divisor and emits a receive-sample tick. A second counter divides those sample ticks by the oversampling ratio and emits a transmit-bit tick. The baud rate is therefore `clk / (divisor × ratio)`, and the receiver sees `ratio` sample ticks per bit.

Both outputs are one-cycle enable strobes in the module-clock domain, not derived clocks. Downstream transmit and receive logic qualifies its registers with them. A divisor of zero switches the generator off. An oversampling field below its legal range falls back to 16× oversampling. Any change of settings, or a rising enable, restarts both counters from zero, so no period comes out shortened or stretched.

Top module: `uart_tick_gen`

## Requirements
- R1: With the 13-bit `divisor` field set to D (1 to 8191) and the generator running, `sample_tick` is high once every D clock cycles.
- R2: While `divisor` is 0, neither `sample_tick` nor `bit_tick` is ever high.
- R3: For D greater than 1, every `sample_tick` pulse lasts exactly one cycle. For D equal to 1, `sample_tick` is high on every running cycle.
- R4: `bit_tick` is high only in a cycle where `sample_tick` is also high. It fires on every R-th sample tick, where R is the oversampling ratio, so its period is D×R cycles.
- R5: The 5-bit `osr` field holds R−1. Values 3 to 31 give R from 4 to 32. Values 0, 1 and 2 are treated as 15, giving R = 16.
- R6: A change of `divisor` or of the effective `osr` clears both counters. Counting the cycle in which the new value is first applied as cycle 1, the first `sample_tick` comes in cycle D+1 and the first `bit_tick` in cycle D×R+1.
- R7: While `en` is low, no tick is produced and both counters are held at zero. When `en` rises, timing restarts exactly as in R6.
- R8: While `rst_n` is low, both tick outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low clears both counters |
| divisor | input | 13 | First-stage modulo divisor; 0 switches the generator off |
| osr | input | 5 | Oversampling ratio minus one; values below 3 select 15 |
| sample_tick | output | 1 | One-cycle receive-sample strobe |
| bit_tick | output | 1 | One-cycle transmit-bit strobe |

## Verification
The bench builds the block with its default widths: a 13-bit divisor and a 5-bit oversampling field. This brings the whole legal range within reach, including the largest divisor 8191, the smallest ratio 4, the largest ratio 32 and the three fallback codes. Short divisors keep most periods brief. One run at divisor 8191 covers the wide end of the first counter. Mid-period reconfiguration and enable toggling show that counting restarts from a clean zero.

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV_W    = 13,
  parameter int OSR_W    = 5,
  parameter int OSR_MIN  = 3,
  parameter int OSR_DFLT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [OSR_W-1:0] osr,
  output logic             sample_tick,
  output logic             bit_tick
);

  logic [DIV_W-1:0] div_cnt, div_q;
  logic [OSR_W-1:0] osr_cnt, osr_q, osr_eff;
  logic             en_q, hold;

  assign osr_eff = (osr < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_DFLT) : osr;

  assign hold = !en || !en_q || (divisor == '0) ||
                (divisor != div_q) || (osr_eff != osr_q);

  assign sample_tick = !hold && (div_cnt == divisor - DIV_W'(1));
  assign bit_tick    = sample_tick && (osr_cnt == osr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      div_q   <= '0;
      osr_q   <= '0;
      div_cnt <= '0;
      osr_cnt <= '0;
    end else begin
      en_q  <= en;
      div_q <= divisor;
      osr_q <= osr_eff;
      if (hold) begin
        div_cnt <= '0;
        osr_cnt <= '0;
      end else begin
        div_cnt <= sample_tick ? '0 : div_cnt + DIV_W'(1);
        if (bit_tick)         osr_cnt <= '0;
        else if (sample_tick) osr_cnt <= osr_cnt + OSR_W'(1);
      end
    end
  end

  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (!sample_tick && !bit_tick)); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && div_q > DIV_W'(1)) |=> !sample_tick); // R3

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R4

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (osr_q >= OSR_W'(OSR_MIN) && osr_cnt <= osr_q)); // R5

  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != div_q) |=> (div_cnt == '0 && osr_cnt == '0)); // R6

  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (div_cnt == '0 && osr_cnt == '0 && !sample_tick)); // R7

  always_comb begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (!sample_tick && !bit_tick); // R8
  end

endmodule

// File: tb/uart_tick_gen_tb.sv
module uart_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [12:0] divisor = '0;
  logic [4:0]  osr = '0;
  logic        sample_tick, bit_tick;

  typedef struct {
    int    period;
    int    samples;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail = 0;
  int   cyc_cnt = 0;
  int   samp_cnt = 0;
  int   tick_total = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  uart_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor), .osr(osr),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_cnt++;
    if (sample_tick) samp_cnt++;
    if (sample_tick || bit_tick) tick_total++;
    if (bit_tick) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc_cnt == e.period, {e.req, " bit period"}, cyc_cnt, e.period);
        check(samp_cnt == e.samples, {e.req, " samples per bit"}, samp_cnt, e.samples);
      end
      cyc_cnt = 0;
      samp_cnt = 0;
    end
  end

  task automatic configure(input bit e, input int d, input int o);
    @(posedge clk); #1;
    en = e;
    divisor = 13'(d);
    osr = 5'(o);
    exp_q.delete();
    cyc_cnt = 0;
    samp_cnt = 0;
  endtask

  task automatic expect_bits(input int d, input int ratio, input int n, input string req);
    int p;
    int guard;
    p = d * ratio;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.period = (i == 0) ? p + 1 : p;
      e.samples = ratio;
      e.req = req;
      exp_q.push_back(e);
    end
    guard = 0;
    while (exp_q.size() > 0 && guard < p * (n + 2) + 10) begin
      @(posedge clk);
      guard++;
    end
    check(exp_q.size() == 0, {req, " bit ticks seen"}, n - exp_q.size(), n);
    exp_q.delete();
  endtask

  task automatic expect_silence(input int cycles, input string req);
    int start;
    start = tick_total;
    repeat (cycles) @(posedge clk);
    check(tick_total == start, {req, " no ticks"}, tick_total - start, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!sample_tick && !bit_tick, "R8 reset", int'(sample_tick) + int'(bit_tick), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1, R3: divisor 1 gives a tick every cycle; ratio 4
    configure(1, 1, 3);
    expect_bits(1, 4, 3, "R3");
    // R1, R5: largest ratio 32
    configure(1, 3, 31);
    expect_bits(3, 32, 2, "R5");
    // R5: codes 0, 1, 2 fall back to 16x
    configure(1, 5, 0);
    expect_bits(5, 16, 2, "R5");
    configure(1, 2, 2);
    expect_bits(2, 16, 2, "R5");
    configure(1, 7, 1);
    expect_bits(7, 16, 1, "R5");
    // R4: ratio 8
    configure(1, 2, 7);
    expect_bits(2, 8, 3, "R4");
    // R1: widest divisor
    configure(1, 8191, 3);
    expect_bits(8191, 4, 1, "R1");
    // R2: divisor zero shuts the generator off
    configure(1, 0, 7);
    expect_silence(300, "R2");
    // R6: change in mid-period restarts cleanly
    configure(1, 4, 3);
    repeat (7) @(posedge clk);
    configure(1, 6, 4);
    expect_bits(6, 5, 2, "R6");
    configure(1, 6, 9);
    expect_bits(6, 10, 1, "R6");
    // R7: enable low silences, rising enable restarts
    configure(1, 5, 3);
    repeat (9) @(posedge clk);
    configure(0, 5, 3);
    expect_silence(200, "R7");
    configure(1, 5, 3);
    expect_bits(5, 4, 2, "R7");

    done = 1'b1;
  end

  initial begin
    int waited;
    waited = 0;
    while (!done && waited < 190000) begin
      @(posedge clk);
      waited++;
    end
    if (!done) check(1'b0, "watchdog", waited, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule